// File: doc/BRIEF.md
# Register Rename Map with Physical Tag Pool

This block renames a group of up to `LANES` instructions per cycle from the 32 architectural registers onto a pool of `PHYS_REGS` physical tags. It keeps a table that maps each architectural register to its current physical tag, a ready bit for every physical tag, and a circular queue of the tags that are not in use. For each lane it returns the physical tags of the two sources with their ready bits, the tag newly assigned to the destination, and the tag the destination held before. The reorder buffer stores that earlier tag and returns it here when the instruction retires.

Lanes are handled strictly in program order. A later lane in the same group sees the mappings made by earlier lanes. A group is renamed completely or not at all: if the free queue holds fewer tags than the group has destinations, `stall` rises and no state changes. Freed tags from retirement and result-completion notices can arrive in every cycle, whether or not the group stalls. Register values, scheduling, the reorder buffer and misprediction recovery sit outside this block.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register n maps to physical tag n for n = 0..31, and those 32 tags read as ready.
- R2: After reset, the free queue holds tags 32 to PHYS_REGS-1 and hands them out in ascending order, so the first destination renamed after reset gets tag 32.
- R3: A source whose `req_has_a`/`req_has_b` bit is 0 reads back tag 0 with ready 1. A lane whose `req_has_dst` bit is 0 takes no tag from the free queue and changes no mapping.
- R4: `prev_tag` of a lane with a destination is the tag its architectural register held just before that lane, including a mapping made by an earlier lane of the same group.
- R5: Freed tags join the tail of the free queue in lane order (lane 0 first) and are handed out only after every tag already queued.
- R6: `stall` is 1 in a cycle exactly when the number of valid lanes with a destination exceeds the number of queued free tags. A stalled group changes no mapping and takes no tag.
- R7: A source that names the destination of an earlier lane in the same group reads that lane's new tag with ready 0.
- R8: A newly assigned tag reads as not ready. A completion on `done_tag` makes that tag read as ready from the next cycle on, not in the cycle of the completion.
- R9: A tag freed in one cycle cannot be assigned in that same cycle. It can be assigned from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | LANES | Lane holds an instruction to rename |
| req_has_dst | input | LANES | Lane writes a destination register |
| req_dst | input | LANES x 5 | Destination architectural register |
| req_has_a | input | LANES | First source is present |
| req_src_a | input | LANES x 5 | First source architectural register |
| req_has_b | input | LANES | Second source is present |
| req_src_b | input | LANES x 5 | Second source architectural register |
| stall | output | 1 | Group cannot be renamed this cycle |
| src_a_tag | output | LANES x TW | Physical tag of the first source |
| src_a_rdy | output | LANES | First source tag is ready |
| src_b_tag | output | LANES x TW | Physical tag of the second source |
| src_b_rdy | output | LANES | Second source tag is ready |
| dst_tag | output | LANES x TW | Newly assigned destination tag (0 when there is no destination) |
| prev_tag | output | LANES x TW | Previous mapping of the destination (0 when there is no destination) |
| ret_valid | input | LANES | Retirement returns a tag on this lane |
| ret_tag | input | LANES x TW | Tag to return to the free queue |
| done_valid | input | LANES | Completion notice on this lane |
| done_tag | input | LANES x TW | Tag whose result has completed |

## Verification
All lookup results, `dst_tag`, `prev_tag` and `stall` are combinational and due in the same cycle as the request. Mapping updates, tag handouts, frees and completions take effect at the next rising edge and show from the following cycle. The bench therefore drives each request on the falling edge and samples 2 ns later, before the rising edge that commits it. An effect that is due a cycle later is checked by a fresh request one cycle on. The completion and free checks also sample in the cycle of the event itself, to confirm that nothing shows early.

// File: rtl/rn_pkg.sv
package rn_pkg;
   localparam int ARCH_REGS = 32;
   localparam int AREG_W    = $clog2(ARCH_REGS);
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist #(
   parameter int LANES = 4,
   parameter int DEPTH = 32,
   parameter int TW    = 6,
   parameter int BASE  = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(LANES+1)-1:0] pop_n,
   input  logic [LANES-1:0]           push_v,
   input  logic [LANES-1:0][TW-1:0]   push_tag,
   output logic [LANES-1:0][TW-1:0]   head_tags,
   output logic [$clog2(DEPTH+1)-1:0] avail
);
   localparam int CW = $clog2(LANES + 1);
   localparam int DW = $clog2(DEPTH + 1);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   initial assert (LANES <= DEPTH) else $error("free queue shallower than lane count");

   logic [TW-1:0] slot_q [DEPTH];
   logic [PW-1:0] head_q, tail_q;
   logic [DW-1:0] cnt_q;
   logic [PW-1:0] push_pos [LANES];
   logic [CW-1:0] push_n;

   function automatic logic [PW-1:0] wrap(input int base_i, input int off);
      int s;
      s = base_i + off;
      if (s >= DEPTH) s = s - DEPTH;
      return PW'(s);
   endfunction

   always_comb begin
      for (int k = 0; k < LANES; k++)
         head_tags[k] = slot_q[wrap(int'(head_q), k)];
   end

   always_comb begin
      int pos;
      pos = 0;
      for (int k = 0; k < LANES; k++) begin
         push_pos[k] = wrap(int'(tail_q), pos);
         if (push_v[k]) pos = pos + 1;
      end
      push_n = CW'(pos);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) slot_q[i] <= TW'(BASE + i);
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= DW'(DEPTH);
      end else begin
         for (int k = 0; k < LANES; k++)
            if (push_v[k]) slot_q[push_pos[k]] <= push_tag[k];
         head_q <= wrap(int'(head_q), int'(pop_n));
         tail_q <= wrap(int'(tail_q), int'(push_n));
         cnt_q  <= DW'(int'(cnt_q) + int'(push_n) - int'(pop_n));
      end
   end

   assign avail = cnt_q;

   // R5: returned tags never exceed the queue capacity
   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cnt_q) + int'(push_n) - int'(pop_n)) <= DEPTH);
   // R6: the rename side never takes more tags than are queued
   p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pop_n) <= int'(cnt_q));
endmodule

// File: rtl/rn_map.sv
module rn_map
   import rn_pkg::*;
#(
   parameter int LANES     = 4,
   parameter int PHYS_REGS = 64,
   parameter int TW        = 6
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         fire,
   input  logic [LANES-1:0]             req_valid,
   input  logic [LANES-1:0]             req_has_dst,
   input  logic [LANES-1:0][AREG_W-1:0] req_dst,
   input  logic [LANES-1:0]             req_has_a,
   input  logic [LANES-1:0][AREG_W-1:0] req_src_a,
   input  logic [LANES-1:0]             req_has_b,
   input  logic [LANES-1:0][AREG_W-1:0] req_src_b,
   input  logic [LANES-1:0][TW-1:0]     new_tag,
   input  logic [LANES-1:0]             done_valid,
   input  logic [LANES-1:0][TW-1:0]     done_tag,
   output logic [LANES-1:0][TW-1:0]     src_a_tag,
   output logic [LANES-1:0]             src_a_rdy,
   output logic [LANES-1:0][TW-1:0]     src_b_tag,
   output logic [LANES-1:0]             src_b_rdy,
   output logic [LANES-1:0][TW-1:0]     prev_tag
);
   logic [TW-1:0]        map_q   [ARCH_REGS];
   logic [TW-1:0]        map_w   [ARCH_REGS];
   logic [PHYS_REGS-1:0] rdy_q, rdy_w, alloc_mask, done_mask;

   always_comb begin
      map_w      = map_q;
      rdy_w      = rdy_q;
      alloc_mask = '0;
      for (int i = 0; i < LANES; i++) begin
         src_a_tag[i] = req_has_a[i] ? map_w[req_src_a[i]] : '0;
         src_a_rdy[i] = req_has_a[i] ? rdy_w[src_a_tag[i]] : 1'b1;
         src_b_tag[i] = req_has_b[i] ? map_w[req_src_b[i]] : '0;
         src_b_rdy[i] = req_has_b[i] ? rdy_w[src_b_tag[i]] : 1'b1;
         prev_tag[i]  = '0;
         if (req_valid[i] && req_has_dst[i]) begin
            prev_tag[i]            = map_w[req_dst[i]];
            map_w[req_dst[i]]      = new_tag[i];
            rdy_w[new_tag[i]]      = 1'b0;
            alloc_mask[new_tag[i]] = 1'b1;
         end
      end
   end

   always_comb begin
      done_mask = '0;
      for (int i = 0; i < LANES; i++)
         if (done_valid[i]) done_mask[done_tag[i]] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < ARCH_REGS; r++) map_q[r] <= TW'(r);
         for (int p = 0; p < PHYS_REGS; p++) rdy_q[p] <= (p < ARCH_REGS);
      end else begin
         if (fire) map_q <= map_w;
         rdy_q <= (rdy_q | done_mask) & ~(fire ? alloc_mask : '0);
      end
   end

   // R8: a tag handed out on lane 0 reads not ready afterwards
   p_new_unready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fire && req_valid[0] && req_has_dst[0] |=> !rdy_q[$past(new_tag[0])]);
   // R8: a completed tag that is not reassigned reads ready afterwards
   p_done_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid[0] && !(fire && alloc_mask[done_tag[0]]) |=> rdy_q[$past(done_tag[0])]);
   // R7: the last lane's destination mapping is the one that survives
   p_last_lane_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fire && req_valid[LANES-1] && req_has_dst[LANES-1]
      |=> map_q[$past(req_dst[LANES-1])] == $past(new_tag[LANES-1]));
   // R6: without a committed group the mapping table holds still
   p_map_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> map_q[0] == $past(map_q[0]));
endmodule

// File: rtl/reg_rename.sv
module reg_rename
   import rn_pkg::*;
#(
   parameter int LANES     = 4,
   parameter int PHYS_REGS = 64,
   localparam int TW       = $clog2(PHYS_REGS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [LANES-1:0]             req_valid,
   input  logic [LANES-1:0]             req_has_dst,
   input  logic [LANES-1:0][AREG_W-1:0] req_dst,
   input  logic [LANES-1:0]             req_has_a,
   input  logic [LANES-1:0][AREG_W-1:0] req_src_a,
   input  logic [LANES-1:0]             req_has_b,
   input  logic [LANES-1:0][AREG_W-1:0] req_src_b,
   output logic                         stall,
   output logic [LANES-1:0][TW-1:0]     src_a_tag,
   output logic [LANES-1:0]             src_a_rdy,
   output logic [LANES-1:0][TW-1:0]     src_b_tag,
   output logic [LANES-1:0]             src_b_rdy,
   output logic [LANES-1:0][TW-1:0]     dst_tag,
   output logic [LANES-1:0][TW-1:0]     prev_tag,
   input  logic [LANES-1:0]             ret_valid,
   input  logic [LANES-1:0][TW-1:0]     ret_tag,
   input  logic [LANES-1:0]             done_valid,
   input  logic [LANES-1:0][TW-1:0]     done_tag
);
   localparam int DEPTH = PHYS_REGS - ARCH_REGS;
   localparam int CW    = $clog2(LANES + 1);
   localparam int DW    = $clog2(DEPTH + 1);

   initial assert (PHYS_REGS > ARCH_REGS) else $error("pool must exceed architectural count");
   initial assert (LANES >= 1) else $error("need at least one lane");

   logic [LANES-1:0][TW-1:0] head_tags, new_tag;
   logic [DW-1:0]            avail;
   logic [CW-1:0]            need, pop_n;
   logic                     fire;

   always_comb begin
      int n;
      n = 0;
      for (int i = 0; i < LANES; i++) begin
         new_tag[i] = head_tags[n];
         if (req_valid[i] && req_has_dst[i]) n = n + 1;
      end
      need = CW'(n);
   end

   assign stall = int'(need) > int'(avail);
   assign fire  = (|req_valid) && !stall;
   assign pop_n = fire ? need : '0;

   for (genvar g = 0; g < LANES; g++) begin : g_dst
      assign dst_tag[g] = (req_valid[g] && req_has_dst[g]) ? new_tag[g] : '0;
   end

   rn_freelist #(.LANES(LANES), .DEPTH(DEPTH), .TW(TW), .BASE(ARCH_REGS)) u_free (
      .clk(clk), .rst_n(rst_n), .pop_n(pop_n), .push_v(ret_valid),
      .push_tag(ret_tag), .head_tags(head_tags), .avail(avail)
   );

   rn_map #(.LANES(LANES), .PHYS_REGS(PHYS_REGS), .TW(TW)) u_map (
      .clk(clk), .rst_n(rst_n), .fire(fire), .req_valid(req_valid),
      .req_has_dst(req_has_dst), .req_dst(req_dst), .req_has_a(req_has_a),
      .req_src_a(req_src_a), .req_has_b(req_has_b), .req_src_b(req_src_b),
      .new_tag(new_tag), .done_valid(done_valid), .done_tag(done_tag),
      .src_a_tag(src_a_tag), .src_a_rdy(src_a_rdy), .src_b_tag(src_b_tag),
      .src_b_rdy(src_b_rdy), .prev_tag(prev_tag)
   );

   // R6: a stalled group leaves the free-queue level unchanged apart from frees
   p_stall_no_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stall && !(|ret_valid) |=> avail == $past(avail));
endmodule

// File: tb/tb_reg_rename.sv
module tb_reg_rename;
   localparam int L  = 2;
   localparam int TW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [L-1:0] req_valid = '0, req_has_dst = '0, req_has_a = '0, req_has_b = '0;
   logic [L-1:0][4:0] req_dst = '0, req_src_a = '0, req_src_b = '0;
   logic stall;
   logic [L-1:0][TW-1:0] src_a_tag, src_b_tag, dst_tag, prev_tag;
   logic [L-1:0] src_a_rdy, src_b_rdy;
   logic [L-1:0] ret_valid = '0, done_valid = '0;
   logic [L-1:0][TW-1:0] ret_tag = '0, done_tag = '0;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   reg_rename #(.LANES(L), .PHYS_REGS(64)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_has_dst(req_has_dst),
      .req_dst(req_dst), .req_has_a(req_has_a), .req_src_a(req_src_a),
      .req_has_b(req_has_b), .req_src_b(req_src_b), .stall(stall),
      .src_a_tag(src_a_tag), .src_a_rdy(src_a_rdy), .src_b_tag(src_b_tag),
      .src_b_rdy(src_b_rdy), .dst_tag(dst_tag), .prev_tag(prev_tag),
      .ret_valid(ret_valid), .ret_tag(ret_tag), .done_valid(done_valid),
      .done_tag(done_tag)
   );

   typedef struct packed {
      logic [4:0] d0, s0, d1, s1;
      logic [5:0] t0, o0, a0, t1, o1, a1;
   } vec_t;

   // dst/src per lane, then expected new tag, previous tag, source tag per lane
   localparam vec_t VEC [4] = '{
      '{5'd1, 5'd1, 5'd2, 5'd1, 6'd32, 6'd1,  6'd1,  6'd33, 6'd2,  6'd32},
      '{5'd1, 5'd2, 5'd1, 5'd1, 6'd34, 6'd32, 6'd33, 6'd35, 6'd34, 6'd34},
      '{5'd5, 5'd1, 5'd3, 5'd5, 6'd36, 6'd5,  6'd35, 6'd37, 6'd3,  6'd36},
      '{5'd0, 5'd3, 5'd2, 5'd0, 6'd38, 6'd0,  6'd37, 6'd39, 6'd33, 6'd38}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d, want %0d", req, act, exp);
      end
   endtask

   task automatic idle();
      req_valid = '0; req_has_dst = '0; req_has_a = '0; req_has_b = '0;
      ret_valid = '0; done_valid = '0;
   endtask

   task automatic lane(input int i, input bit hd, input int d, input bit ha, input int a);
      req_valid[i] = 1'b1; req_has_dst[i] = hd; req_dst[i] = 5'(d);
      req_has_a[i] = ha; req_src_a[i] = 5'(a); req_has_b[i] = 1'b0;
   endtask

   initial begin
      #200000;
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got 0, want 1");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset mapping and absent operands, no destination taken
      @(negedge clk); idle();
      lane(0, 1'b0, 0, 1'b1, 7); req_has_b[0] = 1'b1; req_src_b[0] = 5'd31;
      lane(1, 1'b0, 0, 1'b0, 0);
      #2;
      chk("R1 src a tag", int'(src_a_tag[0]), 7);
      chk("R1 src a rdy", int'(src_a_rdy[0]), 1);
      chk("R1 src b tag", int'(src_b_tag[0]), 31);
      chk("R1 src b rdy", int'(src_b_rdy[0]), 1);
      chk("R3 absent tag", int'(src_a_tag[1]), 0);
      chk("R3 absent rdy", int'(src_a_rdy[1]), 1);
      chk("R3 no dst tag", int'(dst_tag[0]), 0);
      chk("R6 no stall", int'(stall), 0);

      // vector table: R2 ascending handout, R4 previous tag, R7 in-group forwarding
      for (int v = 0; v < 4; v++) begin
         @(negedge clk); idle();
         lane(0, 1'b1, int'(VEC[v].d0), 1'b1, int'(VEC[v].s0));
         lane(1, 1'b1, int'(VEC[v].d1), 1'b1, int'(VEC[v].s1));
         #2;
         chk("R2 dst tag lane0", int'(dst_tag[0]), int'(VEC[v].t0));
         chk("R2 dst tag lane1", int'(dst_tag[1]), int'(VEC[v].t1));
         chk("R4 prev lane0", int'(prev_tag[0]), int'(VEC[v].o0));
         chk("R4 prev lane1", int'(prev_tag[1]), int'(VEC[v].o1));
         chk("R7 src lane0", int'(src_a_tag[0]), int'(VEC[v].a0));
         chk("R7 src lane1", int'(src_a_tag[1]), int'(VEC[v].a1));
         chk("R7 fwd unready", int'(src_a_rdy[1]), 0);
      end

      // completion: not ready in its own cycle, ready one cycle later
      @(negedge clk); idle();
      lane(0, 1'b0, 0, 1'b1, 1);
      done_valid[0] = 1'b1; done_tag[0] = 6'd35;
      #2;
      chk("R8 tag of r1", int'(src_a_tag[0]), 35);
      chk("R8 not yet ready", int'(src_a_rdy[0]), 0);
      @(negedge clk); idle();
      lane(0, 1'b0, 0, 1'b1, 1);
      #2;
      chk("R8 ready next cycle", int'(src_a_rdy[0]), 1);

      // drain the remaining 24 tags
      for (int c = 0; c < 12; c++) begin
         @(negedge clk); idle();
         lane(0, 1'b1, 10, 1'b0, 0);
         lane(1, 1'b1, 11, 1'b0, 0);
         #2;
         chk("R6 no stall while tags left", int'(stall), 0);
      end

      // empty queue: stall, and a same-cycle free does not help
      @(negedge clk); idle();
      lane(0, 1'b1, 10, 1'b1, 10);
      ret_valid[0] = 1'b1; ret_tag[0] = 6'd1;
      #2;
      chk("R6 stall when empty", int'(stall), 1);
      chk("R9 free not usable same cycle", int'(stall), 1);

      @(negedge clk); idle();
      lane(0, 1'b0, 0, 1'b1, 10);
      #2;
      chk("R6 stalled group left map", int'(src_a_tag[0]), 62);

      // freed tags handed out next cycle, in queue order
      @(negedge clk); idle();
      lane(0, 1'b1, 12, 1'b0, 0);
      ret_valid[1] = 1'b1; ret_tag[1] = 6'd2;
      #2;
      chk("R9 freed tag usable next cycle", int'(stall), 0);
      chk("R5 first freed tag", int'(dst_tag[0]), 1);

      @(negedge clk); idle();
      lane(0, 1'b1, 13, 1'b0, 0);
      #2;
      chk("R5 second freed tag", int'(dst_tag[0]), 2);
      chk("R5 prev of r13", int'(prev_tag[0]), 13);

      @(negedge clk); idle();
      lane(0, 1'b1, 14, 1'b0, 0);
      lane(1, 1'b1, 15, 1'b0, 0);
      #2;
      chk("R6 stall on two needed", int'(stall), 1);

      @(negedge clk); idle();
      @(negedge clk);
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule